// File: doc/BRIEF.md
# Descending Stack Pointer with Byte and Return-Address Transfers

This block holds the stack pointer of a small 8-bit processor whose stack grows toward lower addresses. The core issues one of four single-cycle commands: store one byte, fetch one byte, store a 16-bit return address (subroutine call or handler entry), or fetch a return address (subroutine or handler return). For each command the block drives a registered data-memory port: address, write strobe, write byte and read strobe. Read bytes come back from a synchronous memory one cycle after the read strobe. The block returns them as a popped byte or as a reassembled 16-bit return address, each with its own valid pulse.

The pointer always names the next free location. A byte store writes at the pointer and then steps down. A byte fetch steps up and then reads at the new value. Return addresses take two back-to-back memory beats, and the block reports itself busy during the second beat. Software sees the pointer as two byte-wide I/O registers. A parameter can drop the upper register, which leaves an 8-bit pointer. A decrement that lands below the first SRAM address raises a one-cycle warning, but the operation still completes.

Top module: `stkptr_unit`

## Requirements
- R1: Reset loads the pointer with SRAM_TOP (masked to 8 bits when the upper register is absent) and leaves busy, mem_we and mem_re low.
- R2: An accepted byte store drives, one cycle after the command, mem_we=1, mem_addr equal to the old pointer and mem_wdata equal to push_data; the pointer becomes the old value minus one.
- R3: An accepted byte fetch raises mem_re one cycle after the command with mem_addr equal to the old pointer plus one, and the pointer takes that value; pop_valid pulses with the read byte three cycles after the command.
- R4: An accepted return-address store makes two writes in consecutive cycles: ret_addr_in[7:0] at the old pointer, then ret_addr_in[15:8] one address lower. busy is high during the second beat, and the net step is minus two.
- R5: An accepted return-address fetch reads the old pointer plus one, then plus two, in consecutive cycles with busy high during the second beat. Four cycles after the command, ret_valid pulses with ret_addr_out = {first byte read, second byte read}. The net step is plus two.
- R6: A command is accepted only when busy is low, no I/O write is present and exactly one of cmd_push, cmd_pop, cmd_call, cmd_ret is high; otherwise it causes no memory access and no pointer change.
- R7: io_sel=0 selects the low pointer byte and io_sel=1 the high byte; io_rdata shows the selected byte one cycle after io_sel is applied, and io_we writes io_wdata to the selected byte.
- R8: An I/O write takes priority over a core command in the same cycle: the command is dropped (no memory strobe) and the written byte takes effect.
- R9: With HAS_HIGH=0, the high byte reads as zero, writes to it are ignored, and the pointer steps modulo 256 with mem_addr upper bits zero.
- R10: out_of_range pulses together with the write beat of any store whose decrement moves the pointer below SRAM_BASE; the store and the decrement still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_push | input | 1 | Store one byte |
| cmd_pop | input | 1 | Fetch one byte |
| cmd_call | input | 1 | Store a return address |
| cmd_ret | input | 1 | Fetch a return address |
| push_data | input | 8 | Byte to store |
| ret_addr_in | input | 16 | Return address to store |
| io_we | input | 1 | Software write to a pointer byte |
| io_sel | input | 1 | 0 selects the low byte, 1 the high byte |
| io_wdata | input | 8 | Software write data |
| io_rdata | output | 8 | Selected pointer byte, registered |
| mem_addr | output | ADDR_W | Data-memory address |
| mem_we | output | 1 | Data-memory write strobe |
| mem_wdata | output | 8 | Data-memory write byte |
| mem_re | output | 1 | Data-memory read strobe |
| mem_rdata | input | 8 | Read byte, valid one cycle after mem_re |
| pop_data | output | 8 | Fetched byte |
| pop_valid | output | 1 | Pulse: pop_data valid |
| ret_addr_out | output | 16 | Fetched return address |
| ret_valid | output | 1 | Pulse: ret_addr_out valid |
| busy | output | 1 | Second beat of a return-address transfer |
| out_of_range | output | 1 | Pulse: a store moved the pointer below SRAM_BASE |

## Verification
The busy window lasts one cycle, so the hard case is a command that arrives exactly in that cycle. The bench reaches it by switching from cmd_call to cmd_push on the negative edge that follows the first beat. It then confirms that only the second beat's write appears and that the pointer moved by exactly two. Collisions between software and core are forced the same way, with io_we and a command raised on one edge. The below-floor warning needs the pointer placed one above SRAM_BASE through the I/O registers before two stores.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {TAG_NONE = 2'd0, TAG_BYTE = 2'd1, TAG_RHI = 2'd2, TAG_RLO = 2'd3} rd_tag_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CALL2 = 2'd1, ST_RET2 = 2'd2} seq_st_e;
  typedef enum logic [1:0] {STEP_NONE = 2'd0, STEP_DOWN = 2'd1, STEP_UP = 2'd2} step_e;
endpackage

// File: rtl/stk_ptr_reg.sv
// Pointer register with split byte access; software write wins over stepping.
module stk_ptr_reg
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,   // 9..16
  parameter bit HAS_HIGH = 1'b1,
  parameter logic [ADDR_W-1:0] RESET_VAL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  step_e             step,
  input  logic              io_we,
  input  logic              io_sel,
  input  logic [7:0]        io_wdata,
  output logic [ADDR_W-1:0] sp_o,
  output logic [7:0]        io_rdata
);
  localparam int unsigned HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic [7:0]        lo_q;
  logic [HI_W-1:0]   hi_val;
  logic [ADDR_W-1:0] sp_step;

  assign sp_o = {hi_val, lo_q};

  always_comb begin
    case (step)
      STEP_DOWN: sp_step = sp_o - ONE;
      STEP_UP:   sp_step = sp_o + ONE;
      default:   sp_step = sp_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= RESET_VAL[7:0];
    end else if (io_we) begin
      if (!io_sel) lo_q <= io_wdata;
    end else begin
      lo_q <= sp_step[7:0];
    end
  end

  generate
    if (HAS_HIGH) begin : g_hi
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_q <= RESET_VAL[ADDR_W-1:8];
        end else if (io_we) begin
          if (io_sel) hi_q <= io_wdata[HI_W-1:0];
        end else begin
          hi_q <= sp_step[ADDR_W-1:8];
        end
      end
      assign hi_val = hi_q;
    end else begin : g_nohi
      assign hi_val = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else     io_rdata <= io_sel ? 8'(hi_val) : lo_q;
  end
endmodule

// File: rtl/stk_seq.sv
// Command acceptance, two-beat sequencing and registered memory port.
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PTR_MASK = '1,
  parameter logic [ADDR_W-1:0] BASE_V = 'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_push,
  input  logic              cmd_pop,
  input  logic              cmd_call,
  input  logic              cmd_ret,
  input  logic [7:0]        push_data,
  input  logic [15:0]       ret_addr_in,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] sp,
  output step_e             step,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  output rd_tag_e           rd_tag,
  output logic              busy,
  output logic              out_of_range
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  seq_st_e           st_q;
  logic [7:0]        hi_byte_q;
  logic              accept;
  logic [ADDR_W-1:0] sp_up;
  logic              at_floor;

  assign accept   = (st_q == ST_IDLE) && !io_we
                    && $onehot({cmd_push, cmd_pop, cmd_call, cmd_ret});
  assign sp_up    = (sp + ONE) & PTR_MASK;
  assign at_floor = (sp <= BASE_V);
  assign busy     = (st_q != ST_IDLE);

  always_comb begin
    step = STEP_NONE;
    case (st_q)
      ST_IDLE: begin
        if (accept && (cmd_push || cmd_call)) step = STEP_DOWN;
        else if (accept)                      step = STEP_UP;
      end
      ST_CALL2: step = STEP_DOWN;
      ST_RET2:  step = STEP_UP;
      default:  step = STEP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      hi_byte_q    <= '0;
      mem_addr     <= '0;
      mem_we       <= 1'b0;
      mem_wdata    <= '0;
      mem_re       <= 1'b0;
      rd_tag       <= TAG_NONE;
      out_of_range <= 1'b0;
    end else begin
      mem_we       <= 1'b0;
      mem_re       <= 1'b0;
      rd_tag       <= TAG_NONE;
      out_of_range <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (cmd_push) begin
              mem_we       <= 1'b1;
              mem_addr     <= sp;
              mem_wdata    <= push_data;
              out_of_range <= at_floor;
            end else if (cmd_pop) begin
              mem_re   <= 1'b1;
              mem_addr <= sp_up;
              rd_tag   <= TAG_BYTE;
            end else if (cmd_call) begin
              mem_we       <= 1'b1;
              mem_addr     <= sp;
              mem_wdata    <= ret_addr_in[7:0];
              hi_byte_q    <= ret_addr_in[15:8];
              out_of_range <= at_floor;
              st_q         <= ST_CALL2;
            end else begin
              mem_re   <= 1'b1;
              mem_addr <= sp_up;
              rd_tag   <= TAG_RHI;
              st_q     <= ST_RET2;
            end
          end
        end
        ST_CALL2: begin
          mem_we       <= 1'b1;
          mem_addr     <= sp;
          mem_wdata    <= hi_byte_q;
          out_of_range <= at_floor;
          st_q         <= ST_IDLE;
        end
        ST_RET2: begin
          mem_re   <= 1'b1;
          mem_addr <= sp_up;
          rd_tag   <= TAG_RLO;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_rd_pipe.sv
// Collects bytes from the synchronous memory and forms fetch results.
module stk_rd_pipe
  import stk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  rd_tag_e     rd_tag,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  pop_data,
  output logic        pop_valid,
  output logic [15:0] ret_addr_out,
  output logic        ret_valid
);
  rd_tag_e    tag_d;
  logic [7:0] hi_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_d        <= TAG_NONE;
      hi_hold      <= '0;
      pop_data     <= '0;
      pop_valid    <= 1'b0;
      ret_addr_out <= '0;
      ret_valid    <= 1'b0;
    end else begin
      tag_d     <= rd_tag;
      pop_valid <= 1'b0;
      ret_valid <= 1'b0;
      case (tag_d)
        TAG_BYTE: begin
          pop_data  <= mem_rdata;
          pop_valid <= 1'b1;
        end
        TAG_RHI: hi_hold <= mem_rdata;
        TAG_RLO: begin
          ret_addr_out <= {hi_hold, mem_rdata};
          ret_valid    <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter bit HAS_HIGH = 1'b1,
  parameter int unsigned SRAM_BASE = 'h0100,
  parameter int unsigned SRAM_TOP = 'h08FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_push,
  input  logic              cmd_pop,
  input  logic              cmd_call,
  input  logic              cmd_ret,
  input  logic [7:0]        push_data,
  input  logic [15:0]       ret_addr_in,
  input  logic              io_we,
  input  logic              io_sel,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        pop_data,
  output logic              pop_valid,
  output logic [15:0]       ret_addr_out,
  output logic              ret_valid,
  output logic              busy,
  output logic              out_of_range
);
  localparam logic [ADDR_W-1:0] PTR_MASK  = HAS_HIGH ? {ADDR_W{1'b1}} : ADDR_W'(8'hFF);
  localparam logic [ADDR_W-1:0] RESET_VAL = ADDR_W'(SRAM_TOP) & PTR_MASK;
  localparam logic [ADDR_W-1:0] BASE_V    = ADDR_W'(SRAM_BASE) & PTR_MASK;

  step_e             step_w;
  rd_tag_e           tag_w;
  logic [ADDR_W-1:0] sp_w;

  stk_ptr_reg #(.ADDR_W(ADDR_W), .HAS_HIGH(HAS_HIGH), .RESET_VAL(RESET_VAL)) ptr_i (
    .clk(clk), .rst(rst), .step(step_w), .io_we(io_we), .io_sel(io_sel),
    .io_wdata(io_wdata), .sp_o(sp_w), .io_rdata(io_rdata)
  );

  stk_seq #(.ADDR_W(ADDR_W), .PTR_MASK(PTR_MASK), .BASE_V(BASE_V)) seq_i (
    .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_pop(cmd_pop),
    .cmd_call(cmd_call), .cmd_ret(cmd_ret), .push_data(push_data),
    .ret_addr_in(ret_addr_in), .io_we(io_we), .sp(sp_w), .step(step_w),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .rd_tag(tag_w), .busy(busy), .out_of_range(out_of_range)
  );

  stk_rd_pipe rd_i (
    .clk(clk), .rst(rst), .rd_tag(tag_w), .mem_rdata(mem_rdata),
    .pop_data(pop_data), .pop_valid(pop_valid),
    .ret_addr_out(ret_addr_out), .ret_valid(ret_valid)
  );
endmodule

// File: rtl/stkptr_unit_chk.sv
module stkptr_unit_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PTR_MASK = '1,
  parameter logic [ADDR_W-1:0] RESET_VAL = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_push,
  input logic              cmd_pop,
  input logic              cmd_call,
  input logic              cmd_ret,
  input logic              io_we,
  input logic              busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic              pop_valid,
  input logic              ret_valid,
  input logic              out_of_range,
  input logic [ADDR_W-1:0] sp
);
  localparam logic [ADDR_W-1:0] ONE = 1;
  logic one_cmd;
  logic acc;
  assign one_cmd = $onehot({cmd_push, cmd_pop, cmd_call, cmd_ret});
  assign acc     = !busy && !io_we && one_cmd;

  p_reset_r1: assert property (@(posedge clk) rst |=> (sp == RESET_VAL) && !busy);
  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_push) |=> (sp == (($past(sp) - ONE) & PTR_MASK)) && mem_we);
  p_pop_step_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_pop) |=> (sp == (($past(sp) + ONE) & PTR_MASK)) && mem_re);
  p_valid_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(pop_valid && ret_valid));
  p_call_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_call) |=> busy && mem_we);
  p_busy_pulse_r4: assert property (@(posedge clk) disable iff (rst) busy |=> !busy);
  p_ret_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_ret) |=> busy && mem_re);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !io_we && !one_cmd) |=> $stable(sp));
  p_mem_excl_r6: assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re));
  p_io_prio_r8: assert property (@(posedge clk) disable iff (rst)
    (io_we && !busy) |=> !mem_we && !mem_re);
  p_hi_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (sp & ~PTR_MASK) == '0);
  p_oor_write_r10: assert property (@(posedge clk) disable iff (rst)
    out_of_range |-> mem_we);
endmodule

bind stkptr_unit stkptr_unit_chk #(.ADDR_W(ADDR_W), .PTR_MASK(PTR_MASK), .RESET_VAL(RESET_VAL)) chk_i (
  .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_call(cmd_call),
  .cmd_ret(cmd_ret), .io_we(io_we), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
  .pop_valid(pop_valid), .ret_valid(ret_valid), .out_of_range(out_of_range), .sp(sp_w)
);

// File: tb/stkptr_unit_tb_top.sv
`timescale 1ns/1ps
module stkptr_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic cmd_push = 0, cmd_pop = 0, cmd_call = 0, cmd_ret = 0;
  logic [7:0]  push_data = 0;
  logic [15:0] ret_addr_in = 0;
  logic io_we = 0, io_sel = 0;
  logic [7:0]  io_wdata = 0, io_rdata;
  logic [15:0] mem_addr;
  logic mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata = 0, pop_data;
  logic pop_valid, ret_valid, busy, oor;
  logic [15:0] ret_addr_out;

  stkptr_unit dut_i (
    .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_call(cmd_call),
    .cmd_ret(cmd_ret), .push_data(push_data), .ret_addr_in(ret_addr_in), .io_we(io_we),
    .io_sel(io_sel), .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .pop_data(pop_data), .pop_valid(pop_valid), .ret_addr_out(ret_addr_out),
    .ret_valid(ret_valid), .busy(busy), .out_of_range(oor)
  );

  // Low-byte-only variant
  logic push2 = 0, io_we2 = 0, io_sel2 = 0;
  logic [7:0]  io_wdata2 = 0, io_rdata2, mem_wdata2, pop_data2;
  logic [15:0] mem_addr2, ret_out2;
  logic mem_we2, mem_re2, pop_v2, ret_v2, busy2, oor2;

  stkptr_unit #(.HAS_HIGH(1'b0), .SRAM_BASE('h60), .SRAM_TOP('hFF)) dut_lo_i (
    .clk(clk), .rst(rst), .cmd_push(push2), .cmd_pop(1'b0), .cmd_call(1'b0),
    .cmd_ret(1'b0), .push_data(8'h77), .ret_addr_in(16'h0), .io_we(io_we2),
    .io_sel(io_sel2), .io_wdata(io_wdata2), .io_rdata(io_rdata2), .mem_addr(mem_addr2),
    .mem_we(mem_we2), .mem_wdata(mem_wdata2), .mem_re(mem_re2), .mem_rdata(8'h00),
    .pop_data(pop_data2), .pop_valid(pop_v2), .ret_addr_out(ret_out2),
    .ret_valid(ret_v2), .busy(busy2), .out_of_range(oor2)
  );

  // Synchronous memory model
  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  logic [7:0]  last_pop;
  logic [15:0] last_ret;
  always @(negedge clk) begin
    if (pop_valid) last_pop = pop_data;
    if (ret_valid) last_ret = ret_addr_out;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_sp(output logic [15:0] v);
    @(negedge clk) io_sel = 0;
    @(negedge clk) v[7:0] = io_rdata; io_sel = 1;
    @(negedge clk) v[15:8] = io_rdata; io_sel = 0;
  endtask

  task automatic write_sp(input logic [15:0] v);
    @(negedge clk) io_we = 1; io_sel = 0; io_wdata = v[7:0];
    @(negedge clk) io_sel = 1; io_wdata = v[15:8];
    @(negedge clk) io_we = 0; io_sel = 0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    push_data = d[7:0]; ret_addr_in = d;
    cmd_push = (op == 0); cmd_pop = (op == 1); cmd_call = (op == 2); cmd_ret = (op == 3);
    @(negedge clk) {cmd_push, cmd_pop, cmd_call, cmd_ret} = 4'b0;
    repeat (5) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;   // 0 byte store, 1 byte fetch, 2 addr store, 3 addr fetch
    logic [15:0] data;
    logic [15:0] sp;
    logic [15:0] res;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{2'd0, 16'h00A1, 16'h08FE, 16'h0000},
    '{2'd0, 16'h00B2, 16'h08FD, 16'h0000},
    '{2'd2, 16'h1234, 16'h08FB, 16'h0000},
    '{2'd3, 16'h0000, 16'h08FD, 16'h1234},
    '{2'd1, 16'h0000, 16'h08FE, 16'h00B2},
    '{2'd1, 16'h0000, 16'h08FF, 16'h00A1},
    '{2'd2, 16'hBEEF, 16'h08FD, 16'h0000},
    '{2'd2, 16'h0102, 16'h08FB, 16'h0000},
    '{2'd3, 16'h0000, 16'h08FD, 16'h0102},
    '{2'd3, 16'h0000, 16'h08FF, 16'hBEEF}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_re", mem_re, 0);
    read_sp(v);
    chk("R1 sp", v, 16'h08FF);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      last_pop = 8'h5A; last_ret = 16'hDEAD;
      run_op(VEC[i].op, VEC[i].data);
      read_sp(v);
      chk($sformatf("R2/R3/R4/R5 vec %0d sp", i), v, VEC[i].sp);
      if (VEC[i].op == 1) chk($sformatf("R3 vec %0d byte", i), {8'h00, last_pop}, VEC[i].res);
      if (VEC[i].op == 3) chk($sformatf("R5 vec %0d addr", i), last_ret, VEC[i].res);
    end

    // R2 port timing
    @(negedge clk) cmd_push = 1; push_data = 8'hC3;
    @(negedge clk);
    chk("R2 we", mem_we, 1); chk("R2 addr", mem_addr, 16'h08FF);
    chk("R2 wdata", mem_wdata, 8'hC3); chk("R2 re", mem_re, 0);
    cmd_push = 0;

    // R3 port timing
    @(negedge clk) cmd_pop = 1;
    @(negedge clk);
    chk("R3 re", mem_re, 1); chk("R3 addr", mem_addr, 16'h08FF);
    cmd_pop = 0;
    @(negedge clk) chk("R3 early valid", pop_valid, 0);
    @(negedge clk) chk("R3 valid", pop_valid, 1); chk("R3 data", pop_data, 8'hC3);

    // R4 beats, R6 command during busy ignored
    @(negedge clk) cmd_call = 1; ret_addr_in = 16'hA55A;
    @(negedge clk);
    chk("R4 busy", busy, 1); chk("R4 beat1 we", mem_we, 1);
    chk("R4 beat1 addr", mem_addr, 16'h08FF); chk("R4 beat1 data", mem_wdata, 8'h5A);
    cmd_call = 0; cmd_push = 1; push_data = 8'hEE;
    @(negedge clk);
    chk("R4 busy end", busy, 0); chk("R4 beat2 we", mem_we, 1);
    chk("R4 beat2 addr", mem_addr, 16'h08FE); chk("R4 beat2 data", mem_wdata, 8'hA5);
    cmd_push = 0;
    @(negedge clk) chk("R6 push during busy no write", mem_we, 0);
    read_sp(v);
    chk("R6 sp after busy push", v, 16'h08FD);

    // R5 beats
    @(negedge clk) cmd_ret = 1;
    @(negedge clk);
    chk("R5 beat1 re", mem_re, 1); chk("R5 beat1 addr", mem_addr, 16'h08FE); chk("R5 busy", busy, 1);
    cmd_ret = 0;
    @(negedge clk) chk("R5 beat2 re", mem_re, 1); chk("R5 beat2 addr", mem_addr, 16'h08FF);
    @(negedge clk) chk("R5 early valid", ret_valid, 0);
    @(negedge clk) chk("R5 valid", ret_valid, 1); chk("R5 addr", ret_addr_out, 16'hA55A);

    // R6 two commands at once
    @(negedge clk) cmd_push = 1; cmd_pop = 1;
    @(negedge clk) chk("R6 multi no strobe", {mem_we, mem_re}, 2'b00);
    cmd_push = 0; cmd_pop = 0;
    read_sp(v);
    chk("R6 multi sp", v, 16'h08FF);

    // R8 software write wins
    @(negedge clk) io_we = 1; io_sel = 0; io_wdata = 8'h40; cmd_push = 1;
    @(negedge clk) chk("R8 no write", mem_we, 0);
    io_we = 0; cmd_push = 0;
    read_sp(v);
    chk("R8 sp", v, 16'h0840);

    // R7 write/read of both bytes
    write_sp(16'h0312);
    read_sp(v);
    chk("R7 io rw", v, 16'h0312);

    // R10 floor warning
    write_sp(16'h0101);
    @(negedge clk) cmd_push = 1; push_data = 8'h11;
    @(negedge clk) chk("R10 above floor", oor, 0); cmd_push = 0;
    @(negedge clk) cmd_push = 1; push_data = 8'h22;
    @(negedge clk);
    chk("R10 flag", oor, 1); chk("R10 still writes", mem_we, 1);
    chk("R10 addr", mem_addr, 16'h0100);
    cmd_push = 0;
    read_sp(v);
    chk("R10 sp", v, 16'h00FF);

    // R9 low-only variant
    @(negedge clk) io_sel2 = 0;
    @(negedge clk) chk("R9 reset lo", io_rdata2, 8'hFF);
    io_we2 = 1; io_sel2 = 1; io_wdata2 = 8'h55;
    @(negedge clk) io_we2 = 0;
    @(negedge clk) chk("R9 hi reads zero", io_rdata2, 8'h00);
    io_we2 = 1; io_sel2 = 0; io_wdata2 = 8'h00;
    @(negedge clk) io_we2 = 0; push2 = 1;
    @(negedge clk) push2 = 0;
    chk("R9 addr", mem_addr2, 16'h0000); chk("R9 we", mem_we2, 1);
    io_sel2 = 0;
    @(negedge clk);
    @(negedge clk) chk("R9 wrap lo", io_rdata2, 8'hFF);
    io_sel2 = 1;
    @(negedge clk) chk("R9 wrap hi", io_rdata2, 8'h00);

    finish_run();
  end
endmodule